// File: doc/BRIEF.md
# ASID-Tagged Multi-Size Translation Buffer

This block is a small, fully associative cache of page translations for a 32-bit virtual address space. A requester presents a virtual address together with the current address-space identifier (ASID), a privilege flag and an access kind (read, write or instruction fetch). In the same cycle the block reports whether a cached translation covers the address, the physical address it maps to, and whether the access breaks the page's permissions. On a miss the requester starts a page table walk and writes the walker's result back through the fill port.

Each entry is either global or tagged with an ASID, so switching address spaces only means presenting a different ASID; nothing has to be invalidated. An entry maps one of four page sizes, and the tag compare and the offset pass-through both follow that size. Two invalidation commands exist: one drops every entry and one drops the non-global entries of a single ASID. On a fill, an empty slot is used if one exists; otherwise a round-robin pointer chooses the slot to replace.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so each lookup returns hit=0, fault=0 and a physical address of zero.
- R2: A lookup with lk_valid=1 hits when a valid entry's tag equals the virtual address bits above that entry's page size and the ASID rule holds; otherwise it misses with hit=0, fault=0, pa=0. With lk_valid=0 all three outputs are zero.
- R3: A non-global entry matches only when its ASID equals lk_asid; a global entry matches under any ASID. Looking up under another ASID invalidates nothing: a later lookup under the first ASID hits again.
- R4: Size code 0, 1, 2, 3 selects a 4 KiB, 64 KiB, 1 MiB or 16 MiB page. The physical address takes the frame bits above the page size from the entry and the bits below it from the virtual address.
- R5: fill_perm bit 3 grants supervisor read, bit 2 supervisor write, bit 1 user read, bit 0 user write; lk_priv=1 means supervisor. Access code 0 is a read and needs the read bit of its level, code 1 is a write and needs the write bit, codes 2 and 3 are fetches and need the read bit. A refused access returns hit=1, fault=1 and pa=0.
- R6: A fetch that hits an entry with the no-execute bit set faults even when the read bit allows it; reads of the same page do not fault.
- R7: flush_all invalidates every entry in one cycle, so every lookup misses from the next cycle on. A fill given in the same cycle is discarded as well.
- R8: flush_asid_en invalidates exactly the non-global entries whose ASID equals flush_asid; global entries and entries of other ASIDs remain. An entry filled in the same cycle stays valid even if its ASID matches.
- R9: A fill writes the lowest-numbered invalid slot. When all slots are valid it writes the slot named by a round-robin pointer, which is 0 after reset and advances by one (wrapping) only on such fills.
- R10: Lookups are combinational, with results in the cycle of the request; a fill or flush takes effect on lookups from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_priv | input | 1 | 1 = supervisor access, 0 = user |
| lk_acc | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| lk_hit | output | 1 | A valid entry covers the address |
| lk_pa | output | 32 | Translated address, zero on miss or fault |
| lk_fault | output | 1 | Permission or no-execute violation on a hit |
| fill_en | input | 1 | Write a new entry |
| fill_va | input | 32 | Virtual base of the new entry |
| fill_pa | input | 32 | Physical frame of the new entry |
| fill_asid | input | 8 | ASID tag of the new entry |
| fill_global | input | 1 | New entry matches any ASID |
| fill_size | input | 2 | Page size code of the new entry |
| fill_perm | input | 4 | Permission bits of the new entry |
| fill_nx | input | 1 | No-execute bit of the new entry |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate non-global entries of one ASID |
| flush_asid | input | 8 | ASID to invalidate |

## Verification
The two functions that can share a cycle are a fill and an invalidation, and the outcome depends on which one wins. The bench issues a fill in the same cycle as a per-ASID flush whose ASID equals the new entry's, then confirms by lookup that the new entry survives while the older matching entry is gone and the global and foreign-ASID entries stay. It then issues a fill together with flush_all and confirms that every address, the new one included, misses. A per-ASID flush on a full buffer also frees a middle slot so that the next fill must prefer it over the round-robin pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Smallest page is 4 KiB; each size step adds four address bits.
  localparam int PG_SHIFT = 12;
  localparam int SIZE_STEP = 4;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;

  typedef struct packed {
    logic sup_rd;
    logic sup_wr;
    logic usr_rd;
    logic usr_wr;
  } perm_t;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              e_valid,
  input  logic              e_global,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [1:0]        e_size,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic              match
);
  logic [VPN_W-1:0] cmp_mask;
  logic             tag_eq;
  logic             asid_ok;

  always_comb begin
    cmp_mask = '1 << (SIZE_STEP * int'(e_size));
    tag_eq   = ((e_vpn ^ q_vpn) & cmp_mask) == '0;
    asid_ok  = e_global || (e_asid == q_asid);
    match    = e_valid && tag_eq && asid_ok;
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  logic [3:0] perm,
  input  logic       nx,
  input  logic       priv,
  input  logic [1:0] acc,
  output logic       fault
);
  perm_t p;
  logic  may_rd;
  logic  may_wr;

  always_comb begin
    p      = perm_t'(perm);
    may_rd = priv ? p.sup_rd : p.usr_rd;
    may_wr = priv ? p.sup_wr : p.usr_wr;
    case (acc)
      ACC_READ:  fault = !may_rd;
      ACC_WRITE: fault = !may_wr;
      default:   fault = !may_rd || nx;
    endcase
  end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               full
);
  always_comb begin
    full   = &valid;
    victim = rr_ptr;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) victim = IDX_W'(i);
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_priv,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_fault,
  input  logic              fill_en,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [1:0]        fill_size,
  input  logic [3:0]        fill_perm,
  input  logic              fill_nx,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;

  // Entry storage: valid bits are reset, payload is not.
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] glob_q;
  logic [ENTRIES-1:0] nx_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [3:0]         perm_q [ENTRIES];

  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   victim;
  logic               full;

  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   sel;
  logic               any_hit;
  logic               sel_fault;

  // ---------------- lookup ----------------
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_tag_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
      .e_valid  (valid_q[g]),
      .e_global (glob_q[g]),
      .e_asid   (asid_q[g]),
      .e_vpn    (vpn_q[g]),
      .e_size   (size_q[g]),
      .q_vpn    (lk_va[VA_W-1:PG_SHIFT]),
      .q_asid   (lk_asid),
      .match    (hit_vec[g])
    );
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
    any_hit = |hit_vec;
  end

  tlb_perm_check u_perm (
    .perm  (perm_q[sel]),
    .nx    (nx_q[sel]),
    .priv  (lk_priv),
    .acc   (lk_acc),
    .fault (sel_fault)
  );

  logic [PA_W-1:0] hi_mask;
  logic [PA_W-1:0] frame;
  logic [PA_W-1:0] va_ext;
  logic [PA_W-1:0] pa_raw;

  always_comb begin
    hi_mask  = '1 << (PG_SHIFT + SIZE_STEP * int'(size_q[sel]));
    frame    = {ppn_q[sel], {PG_SHIFT{1'b0}}};
    va_ext   = PA_W'(lk_va);
    pa_raw   = (frame & hi_mask) | (va_ext & ~hi_mask);
    lk_hit   = lk_valid && any_hit;
    lk_fault = lk_hit && sel_fault;
    lk_pa    = (lk_hit && !sel_fault) ? pa_raw : '0;
  end

  // ---------------- replacement ----------------
  tlb_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
    .valid  (valid_q),
    .rr_ptr (rr_q),
    .victim (victim),
    .full   (full)
  );

  // ---------------- update ----------------
  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (flush_asid_en && !glob_q[i] && (asid_q[i] == flush_asid)) valid_d[i] = 1'b0;
    end
    if (fill_en) valid_d[victim] = 1'b1;
    if (flush_all) valid_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      if (fill_en && full) begin
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (fill_en && (victim == IDX_W'(g))) begin
        glob_q[g] <= fill_global;
        nx_q[g]   <= fill_nx;
        asid_q[g] <= fill_asid;
        vpn_q[g]  <= fill_va[VA_W-1:PG_SHIFT];
        ppn_q[g]  <= fill_pa[PA_W-1:PG_SHIFT];
        size_q[g] <= fill_size;
        perm_q[g] <= fill_perm;
      end
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_va,
  input logic            lk_hit,
  input logic [PA_W-1:0] lk_pa,
  input logic            lk_fault,
  input logic            flush_all
);
  // R1: the first cycle after reset finds nothing cached
  a_r1_empty_after_reset: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> !lk_hit);

  // R2: an idle lookup port reports nothing
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_fault && lk_pa == '0));

  // R4: the low 4 KiB offset always passes through on a clean hit
  a_r4_offset_pass: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && !lk_fault) |-> (lk_pa[11:0] == lk_va[11:0]));

  // R5: a fault only accompanies a hit
  a_r5_fault_needs_hit: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> lk_hit);

  // R5: a faulting access gets no address
  a_r5_fault_no_pa: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_pa == '0));

  // R7: after a full flush nothing hits
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> !lk_hit);
endmodule

bind asid_tlb asid_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_va     (lk_va),
  .lk_hit    (lk_hit),
  .lk_pa     (lk_pa),
  .lk_fault  (lk_fault),
  .flush_all (flush_all)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_priv = 1'b0;
  logic [1:0]  lk_acc = 2'd0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic        lk_fault;
  logic        fill_en = 1'b0;
  logic [31:0] fill_va = '0;
  logic [31:0] fill_pa = '0;
  logic [7:0]  fill_asid = '0;
  logic        fill_global = 1'b0;
  logic [1:0]  fill_size = 2'd0;
  logic [3:0]  fill_perm = 4'hF;
  logic        fill_nx = 1'b0;
  logic        flush_all = 1'b0;
  logic        flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

  always #10 clk = ~clk;

  asid_tlb u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_priv(lk_priv), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_fault(lk_fault),
    .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa), .fill_asid(fill_asid),
    .fill_global(fill_global), .fill_size(fill_size), .fill_perm(fill_perm), .fill_nx(fill_nx),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic priv, input logic [1:0] acc);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_priv = priv; lk_acc = acc;
    #2;
  endtask

  task automatic exp_hit(input string tag, input logic [31:0] va, input logic [7:0] asid,
                         input logic priv, input logic [1:0] acc, input logic [31:0] pa);
    look(va, asid, priv, acc);
    chk({tag, " hit"}, 32'(lk_hit), 32'd1);
    chk({tag, " fault"}, 32'(lk_fault), 32'd0);
    chk({tag, " pa"}, lk_pa, pa);
  endtask

  task automatic exp_miss(input string tag, input logic [31:0] va, input logic [7:0] asid);
    look(va, asid, 1'b1, RD);
    chk({tag, " hit"}, 32'(lk_hit), 32'd0);
    chk({tag, " pa"}, lk_pa, 32'd0);
  endtask

  task automatic exp_fault(input string tag, input logic [31:0] va, input logic [7:0] asid,
                           input logic priv, input logic [1:0] acc);
    look(va, asid, priv, acc);
    chk({tag, " hit"}, 32'(lk_hit), 32'd1);
    chk({tag, " fault"}, 32'(lk_fault), 32'd1);
    chk({tag, " pa"}, lk_pa, 32'd0);
  endtask

  task automatic set_fill(input logic [31:0] va, input logic [31:0] pa, input logic [7:0] asid,
                          input logic glob, input logic [1:0] sz, input logic [3:0] perm, input logic nx);
    fill_en = 1'b1; fill_va = va; fill_pa = pa; fill_asid = asid;
    fill_global = glob; fill_size = sz; fill_perm = perm; fill_nx = nx;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [7:0] asid,
                      input logic glob, input logic [1:0] sz, input logic [3:0] perm, input logic nx);
    @(negedge clk);
    set_fill(va, pa, asid, glob, sz, perm, nx);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush_all();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  task automatic do_flush_asid(input logic [7:0] a);
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = a;
    @(negedge clk);
    flush_asid_en = 1'b0;
  endtask

  task automatic t_reset();
    exp_miss("R1 empty after reset", 32'h1234_5678, 8'd0);
    exp_miss("R1 empty other asid", 32'h0000_0000, 8'd7);
  endtask

  task automatic t_basic();
    fill(32'h1234_5000, 32'h8765_4000, 8'd5, 1'b0, 2'd0, 4'hF, 1'b0);
    exp_hit("R2 R10 4K hit", 32'h1234_5ABC, 8'd5, 1'b1, RD, 32'h8765_4ABC);
    exp_miss("R2 neighbour page", 32'h1234_6ABC, 8'd5);
    @(negedge clk);
    lk_valid = 1'b0; lk_va = 32'h1234_5ABC; lk_asid = 8'd5;
    #2;
    chk("R2 idle hit", 32'(lk_hit), 32'd0);
    chk("R2 idle pa", lk_pa, 32'd0);
  endtask

  task automatic t_asid();
    exp_miss("R3 other asid", 32'h1234_5ABC, 8'd6);
    fill(32'h4000_0000, 32'h0400_0000, 8'd9, 1'b1, 2'd0, 4'hF, 1'b0);
    exp_hit("R3 global any asid", 32'h4000_0010, 8'd3, 1'b1, RD, 32'h0400_0010);
    exp_hit("R3 back to old asid", 32'h1234_5004, 8'd5, 1'b1, RD, 32'h8765_4004);
  endtask

  task automatic t_sizes();
    do_flush_all();
    fill(32'h2003_0000, 32'h9000_0000, 8'd1, 1'b0, 2'd1, 4'hF, 1'b0);
    fill(32'h3050_0000, 32'hA010_0000, 8'd1, 1'b0, 2'd2, 4'hF, 1'b0);
    fill(32'h5100_0000, 32'hB200_0000, 8'd1, 1'b0, 2'd3, 4'hF, 1'b0);
    exp_hit("R4 64K", 32'h2003_ABCD, 8'd1, 1'b1, RD, 32'h9000_ABCD);
    exp_miss("R4 64K outside", 32'h2002_ABCD, 8'd1);
    exp_hit("R4 1M", 32'h305F_1234, 8'd1, 1'b1, RD, 32'hA01F_1234);
    exp_hit("R4 16M", 32'h51AB_CDEF, 8'd1, 1'b1, RD, 32'hB2AB_CDEF);
    exp_miss("R4 16M outside", 32'h52AB_CDEF, 8'd1);
  endtask

  task automatic t_perm();
    fill(32'h6000_0000, 32'h0600_0000, 8'd2, 1'b0, 2'd0, 4'b1110, 1'b0);
    fill(32'h6100_0000, 32'h0610_0000, 8'd2, 1'b0, 2'd0, 4'b1100, 1'b0);
    exp_fault("R5 user write to read-only", 32'h6000_0040, 8'd2, 1'b0, WR);
    exp_hit("R5 user read", 32'h6000_0040, 8'd2, 1'b0, RD, 32'h0600_0040);
    exp_hit("R5 supervisor write", 32'h6000_0044, 8'd2, 1'b1, WR, 32'h0600_0044);
    exp_fault("R5 user read of supervisor page", 32'h6100_0008, 8'd2, 1'b0, RD);
    exp_hit("R5 supervisor read", 32'h6100_0008, 8'd2, 1'b1, RD, 32'h0610_0008);
  endtask

  task automatic t_nx();
    fill(32'h7000_0000, 32'h0700_0000, 8'd2, 1'b0, 2'd0, 4'hF, 1'b1);
    fill(32'h7100_0000, 32'h0710_0000, 8'd2, 1'b0, 2'd0, 4'hF, 1'b0);
    exp_fault("R6 fetch no-exec", 32'h7000_0100, 8'd2, 1'b1, FE);
    exp_hit("R6 read no-exec", 32'h7000_0100, 8'd2, 1'b1, RD, 32'h0700_0100);
    exp_hit("R6 fetch exec page", 32'h7100_0100, 8'd2, 1'b0, FE, 32'h0710_0100);
  endtask

  task automatic t_flush_asid();
    do_flush_all();
    fill(32'h1000_0000, 32'h0100_0000, 8'd1, 1'b0, 2'd0, 4'hF, 1'b0);
    fill(32'h1100_0000, 32'h0110_0000, 8'd2, 1'b0, 2'd0, 4'hF, 1'b0);
    fill(32'h1200_0000, 32'h0120_0000, 8'd1, 1'b1, 2'd0, 4'hF, 1'b0);
    @(negedge clk);
    set_fill(32'h1300_0000, 32'h0130_0000, 8'd1, 1'b0, 2'd0, 4'hF, 1'b0);
    flush_asid_en = 1'b1; flush_asid = 8'd1;
    @(negedge clk);
    fill_en = 1'b0; flush_asid_en = 1'b0;
    exp_miss("R8 flushed asid", 32'h1000_0000, 8'd1);
    exp_hit("R8 other asid kept", 32'h1100_0000, 8'd2, 1'b1, RD, 32'h0110_0000);
    exp_hit("R8 global kept", 32'h1200_0000, 8'd1, 1'b1, RD, 32'h0120_0000);
    exp_hit("R8 same-cycle fill kept", 32'h1300_0000, 8'd1, 1'b1, RD, 32'h0130_0000);
  endtask

  task automatic t_flush_all();
    @(negedge clk);
    set_fill(32'h1400_0000, 32'h0140_0000, 8'd2, 1'b1, 2'd0, 4'hF, 1'b0);
    flush_all = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; flush_all = 1'b0;
    exp_miss("R7 same-cycle fill dropped", 32'h1400_0000, 8'd2);
    exp_miss("R7 old entry dropped", 32'h1100_0000, 8'd2);
    exp_miss("R7 global dropped", 32'h1200_0000, 8'd1);
  endtask

  task automatic t_replace();
    do_flush_all();
    for (int i = 0; i < 8; i++)
      fill(32'h8000_0000 + (i << 12), 32'h0800_0000 + (i << 12), (i == 5) ? 8'd4 : 8'd3,
           1'b0, 2'd0, 4'hF, 1'b0);
    exp_hit("R9 slot0 filled", 32'h8000_0000, 8'd3, 1'b1, RD, 32'h0800_0000);
    exp_hit("R9 slot7 filled", 32'h8000_7000, 8'd3, 1'b1, RD, 32'h0800_7000);
    fill(32'h9000_0000, 32'h0900_0000, 8'd3, 1'b0, 2'd0, 4'hF, 1'b0);
    exp_miss("R9 first victim slot0", 32'h8000_0000, 8'd3);
    exp_hit("R9 slot1 kept", 32'h8000_1000, 8'd3, 1'b1, RD, 32'h0800_1000);
    exp_hit("R9 new entry", 32'h9000_0000, 8'd3, 1'b1, RD, 32'h0900_0000);
    fill(32'h9100_0000, 32'h0910_0000, 8'd3, 1'b0, 2'd0, 4'hF, 1'b0);
    exp_miss("R9 second victim slot1", 32'h8000_1000, 8'd3);
    exp_hit("R9 slot2 kept", 32'h8000_2000, 8'd3, 1'b1, RD, 32'h0800_2000);
    do_flush_asid(8'd4);
    exp_miss("R9 slot5 freed", 32'h8000_5000, 8'd4);
    fill(32'h9200_0000, 32'h0920_0000, 8'd3, 1'b0, 2'd0, 4'hF, 1'b0);
    exp_hit("R9 invalid slot preferred", 32'h8000_2000, 8'd3, 1'b1, RD, 32'h0800_2000);
    exp_hit("R9 third new entry", 32'h9200_0000, 8'd3, 1'b1, RD, 32'h0920_0000);
    exp_hit("R9 earlier new entry", 32'h9100_0000, 8'd3, 1'b1, RD, 32'h0910_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_asid();
    t_sizes();
    t_perm();
    t_nx();
    t_flush_asid();
    t_flush_all();
    t_replace();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule